// File: doc/BRIEF.md
# Permission-Checked Set-Associative Tag Directory

This block keeps the tag and state side of a set-associative cache for a cache controller. For every way of every set it holds a line address, a permission state and a lock-owner context. A controller issues one command per cycle against a line-aligned address. The commands are: check an access of a given request kind, test presence, test availability, allocate, deallocate, probe for a victim, write the permission state, lock, unlock and lock test. The block answers on the next cycle. The answer carries hit, way, access-granted, availability and lock-test results, plus the address of the line that replacement would evict.

Replacement recency is tracked with a small age counter per way. Each set's ages always form a permutation of 0 to WAYS-1, and the victim is the way whose age is highest. A request the directory cannot honour changes nothing and raises a sticky error flag. Examples are allocating an address that is already present, allocating into a set with no free way, or working on an absent line.

Top module: `tagdir`

## Requirements
- R1: Each request accepted with `reqValid` high is answered in the next cycle with `rspValid` high. `rspValid` is low in every cycle that follows a cycle without a request.
- R2: The set count is CACHE_BYTES / WAYS / LINE_BYTES. The set index is log2(sets) address bits starting at bit INDEX_START. Equal upper tags in different sets never interfere.
- R3: Command ACCESS (code 0) hits only on a way whose line address matches and whose state is not NotPresent. Permission codes are NotPresent 0, Invalid 1, ReadOnly 2, ReadWrite 3, Busy 4. Request kinds are load 0, fetch 1, store 2, atomic 3. ReadWrite grants every kind; ReadOnly grants only load and fetch; any other state gives a hit without a grant.
- R4: Command PRESENT (code 1) reports hit and the matching way.
- R5: Command AVAIL (code 2) reports available when the set holds the address or at least one NotPresent way.
- R6: Command ALLOC (code 3) takes the lowest-numbered NotPresent way. It stores the line, sets the state to Invalid and sets the lock owner to all ones (no owner). It marks the way most recent only when `reqTouch` is high, and reports the way. Allocating a present address or into a full set is an error.
- R7: Command DEALLOC (code 4) returns the matching way to NotPresent with no owner. Deallocating an absent line is an error.
- R8: Command PROBE (code 5) reports the way with the highest age and its line address. A hit on ACCESS, granted or not, makes that way age 0 and ages every way that was younger by one. At reset, way w of every set has age w. A probe while the set is available is an error.
- R9: Command LOCK (code 6) stores `reqCtx` as owner. UNLOCK (code 7) restores no owner. LOCKTEST (code 8) reports true only when the stored owner equals `reqCtx`. All three are errors on an absent line.
- R10: Command SETPERM (code 9) writes `reqPerm` into the state of a present line. It is an error on an absent line.
- R11: Any error, including a request with nonzero address bits below the line size, leaves the directory unchanged. It sets `errFlag`, which stays high until reset.
- R12: Reset makes every way NotPresent and clears `errFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqCmd | input | 4 | Command code |
| reqAddr | input | ADDR_W | Line-aligned byte address |
| reqKind | input | 2 | Request kind for ACCESS |
| reqPerm | input | 3 | State value for SETPERM |
| reqCtx | input | CTX_W | Context for LOCK and LOCKTEST |
| reqTouch | input | 1 | ALLOC marks the way most recent |
| rspValid | output | 1 | Response strobe |
| rspHit | output | 1 | Address present before the command |
| rspGranted | output | 1 | ACCESS granted |
| rspAvail | output | 1 | Availability result |
| rspLocked | output | 1 | LOCKTEST result |
| rspWay | output | log2(WAYS) | Hit, allocated or victim way |
| rspAddr | output | ADDR_W | Victim line address on PROBE |
| errFlag | output | 1 | Sticky error |

## Verification
Two of the functions interact when a command that updates directory state is followed, in the very next cycle, by one that reads it. Cases include an allocation followed by a presence test, and an access hit that moves recency followed by a victim probe. The bench issues such pairs with `reqValid` held high across both cycles. It judges the second response against the state the first command must have left, for example the probe naming the way that became oldest after the touch. It also provokes an error and a valid response in the same cycle, then confirms through later presence tests that nothing changed.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [3:0] {
    CMD_ACCESS = 4'd0, CMD_PRESENT = 4'd1, CMD_AVAIL = 4'd2, CMD_ALLOC = 4'd3,
    CMD_DEALLOC = 4'd4, CMD_PROBE = 4'd5, CMD_LOCK = 4'd6, CMD_UNLOCK = 4'd7,
    CMD_LOCKTEST = 4'd8, CMD_SETPERM = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    PERM_NONE = 3'd0, PERM_INV = 3'd1, PERM_RO = 3'd2, PERM_RW = 3'd3, PERM_BUSY = 3'd4
  } perm_e;

  typedef enum logic [1:0] {
    KIND_LOAD = 2'd0, KIND_FETCH = 2'd1, KIND_STORE = 2'd2, KIND_ATOMIC = 2'd3
  } kind_e;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic wrTag;
    logic wrPerm;
    logic wrLock;
    logic touch;
  } strobe_t;
endpackage

// File: rtl/tagdir_store.sv
module tagdir_store
  import tagdir_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int SET_W  = 2,
  parameter int LINE_W = 26,
  parameter int CTX_W  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lkSet,
  input  logic [LINE_W-1:0] lkLine,
  input  strobe_t           stb,
  input  logic [WAY_W-1:0]  wrWay,
  input  perm_e             wrPermVal,
  input  logic [CTX_W-1:0]  wrLockVal,
  output logic              hit,
  output logic [WAY_W-1:0]  hitWay,
  output perm_e             hitPerm,
  output logic [CTX_W-1:0]  hitLock,
  output logic              freeAny,
  output logic [WAY_W-1:0]  freeWay,
  output logic [WAY_W-1:0]  victimWay,
  output logic [LINE_W-1:0] victimLine
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [LINE_W-1:0] tagMem  [SETS][WAYS];
  perm_e             permMem [SETS][WAYS];
  logic [CTX_W-1:0]  lockMem [SETS][WAYS];
  logic [WAY_W-1:0]  ageMem  [SETS][WAYS];

  logic [WAYS-1:0] presentV, matchV, victimV;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign presentV[w] = permMem[lkSet][w] != PERM_NONE;
    assign matchV[w]   = presentV[w] && (tagMem[lkSet][w] == lkLine);
    assign victimV[w]  = ageMem[lkSet][w] == OLDEST;
  end

  always_comb begin
    hitWay    = '0;
    freeWay   = '0;
    victimWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchV[w])    hitWay    = WAY_W'(w);
      if (!presentV[w]) freeWay   = WAY_W'(w);
      if (victimV[w])   victimWay = WAY_W'(w);
    end
  end

  assign hit        = |matchV;
  assign freeAny    = ~&presentV;
  assign hitPerm    = permMem[lkSet][hitWay];
  assign hitLock    = lockMem[lkSet][hitWay];
  assign victimLine = tagMem[lkSet][victimWay];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w]  <= '0;
          permMem[s][w] <= PERM_NONE;
          lockMem[s][w] <= '1;
          ageMem[s][w]  <= WAY_W'(w);
        end
      end
    end else begin
      if (stb.wrTag)  tagMem[lkSet][wrWay]  <= lkLine;
      if (stb.wrPerm) permMem[lkSet][wrWay] <= wrPermVal;
      if (stb.wrLock) lockMem[lkSet][wrWay] <= wrLockVal;
      if (stb.touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == wrWay) ageMem[lkSet][w] <= '0;
          else if (ageMem[lkSet][w] < ageMem[lkSet][wrWay])
            ageMem[lkSet][w] <= ageMem[lkSet][w] + 1'b1;
        end
      end
    end
  end

  // a line address is present in at most one way of its set
  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(matchV));
  // ages stay a permutation, so exactly one way is oldest
  assert_one_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(victimV));
endmodule

// File: rtl/tagdir_ctrl.sv
module tagdir_ctrl
  import tagdir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int WAYS   = 4,
  parameter int CTX_W  = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  cmd_e              reqCmd,
  input  kind_e             reqKind,
  input  perm_e             reqPerm,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic              reqTouch,
  input  logic              misalign,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hitWay,
  input  perm_e             hitPerm,
  input  logic [CTX_W-1:0]  hitLock,
  input  logic              freeAny,
  input  logic [WAY_W-1:0]  freeWay,
  input  logic [WAY_W-1:0]  victimWay,
  input  logic [LINE_W-1:0] victimLine,
  output strobe_t           stb,
  output logic [WAY_W-1:0]  wrWay,
  output perm_e             wrPermVal,
  output logic [CTX_W-1:0]  wrLockVal,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspGranted,
  output logic              rspAvail,
  output logic              rspLocked,
  output logic [WAY_W-1:0]  rspWay,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              errFlag
);
  logic avail, grant, err;

  assign avail = hit | freeAny;
  assign grant = hit && (hitPerm == PERM_RW ||
                 (hitPerm == PERM_RO && (reqKind == KIND_LOAD || reqKind == KIND_FETCH)));

  always_comb begin
    stb       = '0;
    wrWay     = hitWay;
    wrPermVal = PERM_NONE;
    wrLockVal = '1;
    err       = 1'b0;
    unique case (reqCmd)
      CMD_ACCESS: stb.touch = hit;
      CMD_ALLOC: begin
        wrWay = freeWay;
        if (!hit && freeAny) begin
          stb.wrTag  = 1'b1;
          stb.wrPerm = 1'b1;
          stb.wrLock = 1'b1;
          stb.touch  = reqTouch;
          wrPermVal  = PERM_INV;
        end else err = 1'b1;
      end
      CMD_DEALLOC: begin
        stb.wrPerm = hit;
        stb.wrLock = hit;
        err        = !hit;
      end
      CMD_PROBE: err = avail;
      CMD_LOCK: begin
        stb.wrLock = hit;
        wrLockVal  = reqCtx;
        err        = !hit;
      end
      CMD_UNLOCK: begin
        stb.wrLock = hit;
        err        = !hit;
      end
      CMD_LOCKTEST: err = !hit;
      CMD_SETPERM: begin
        stb.wrPerm = hit;
        wrPermVal  = reqPerm;
        err        = !hit;
      end
      default: ;
    endcase
    if (misalign) err = 1'b1;
    if (!reqValid || err) stb = '0;
    if (!reqValid) err = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspGranted <= 1'b0;
      rspAvail   <= 1'b0;
      rspLocked  <= 1'b0;
      rspWay     <= '0;
      rspAddr    <= '0;
      errFlag    <= 1'b0;
    end else begin
      rspValid   <= reqValid;
      rspHit     <= hit;
      rspGranted <= reqCmd == CMD_ACCESS && grant;
      rspAvail   <= avail;
      rspLocked  <= reqCmd == CMD_LOCKTEST && hit && hitLock == reqCtx;
      rspWay     <= reqCmd == CMD_ALLOC ? freeWay :
                    reqCmd == CMD_PROBE ? victimWay : hitWay;
      rspAddr    <= reqCmd == CMD_PROBE ? {victimLine, {OFF_W{1'b0}}} : '0;
      errFlag    <= errFlag | err;
    end
  end

  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  assert_grant_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rspGranted |-> rspHit);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);
  assert_no_write_on_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb != '0) |-> reqValid && !misalign);
endmodule

// File: rtl/tagdir.sv
module tagdir
  import tagdir_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 64,
  parameter int INDEX_START = 6,
  parameter int CTX_W       = 4,
  localparam int SETS   = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [3:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [2:0]        reqPerm,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic              reqTouch,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspGranted,
  output logic              rspAvail,
  output logic              rspLocked,
  output logic [WAY_W-1:0]  rspWay,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              errFlag
);
  strobe_t           stb;
  logic [WAY_W-1:0]  wrWay, hitWay, freeWay, victimWay;
  perm_e             wrPermVal, hitPerm;
  logic [CTX_W-1:0]  wrLockVal, hitLock;
  logic              hit, freeAny;
  logic [LINE_W-1:0] victimLine;
  logic [SET_W-1:0]  lkSet;
  logic [LINE_W-1:0] lkLine;
  logic              misalign;

  assign lkSet    = reqAddr[INDEX_START +: SET_W];
  assign lkLine   = reqAddr[ADDR_W-1:OFF_W];
  assign misalign = |reqAddr[OFF_W-1:0];

  tagdir_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS), .CTX_W(CTX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqCmd(cmd_e'(reqCmd)),
    .reqKind(kind_e'(reqKind)), .reqPerm(perm_e'(reqPerm)), .reqCtx(reqCtx),
    .reqTouch(reqTouch), .misalign(misalign), .hit(hit), .hitWay(hitWay),
    .hitPerm(hitPerm), .hitLock(hitLock), .freeAny(freeAny), .freeWay(freeWay),
    .victimWay(victimWay), .victimLine(victimLine), .stb(stb), .wrWay(wrWay),
    .wrPermVal(wrPermVal), .wrLockVal(wrLockVal), .rspValid(rspValid),
    .rspHit(rspHit), .rspGranted(rspGranted), .rspAvail(rspAvail),
    .rspLocked(rspLocked), .rspWay(rspWay), .rspAddr(rspAddr), .errFlag(errFlag)
  );

  tagdir_store #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .LINE_W(LINE_W),
                 .CTX_W(CTX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .lkSet(lkSet), .lkLine(lkLine), .stb(stb),
    .wrWay(wrWay), .wrPermVal(wrPermVal), .wrLockVal(wrLockVal), .hit(hit),
    .hitWay(hitWay), .hitPerm(hitPerm), .hitLock(hitLock), .freeAny(freeAny),
    .freeWay(freeWay), .victimWay(victimWay), .victimLine(victimLine)
  );
endmodule

// File: tb/sim_tagdir.sv
module sim_tagdir;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [3:0] reqCmd = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqKind = '0;
  logic [2:0] reqPerm = '0;
  logic [3:0] reqCtx = '0;
  logic reqTouch = 1'b0;
  logic rspValid, rspHit, rspGranted, rspAvail, rspLocked, errFlag;
  logic [1:0] rspWay;
  logic [AW-1:0] rspAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [3:0] ACC = 0, PRS = 1, AVL = 2, ALC = 3, DAL = 4, PRB = 5,
                         LCK = 6, ULK = 7, LTS = 8, SPM = 9;
  localparam logic [1:0] LD = 0, IF = 1, ST = 2, AT = 3;
  localparam logic [2:0] NP = 0, RO = 2, RW = 3, BSY = 4;

  always #10 clk = ~clk;

  tagdir u0 (.clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqKind(reqKind), .reqPerm(reqPerm), .reqCtx(reqCtx),
    .reqTouch(reqTouch), .rspValid(rspValid), .rspHit(rspHit),
    .rspGranted(rspGranted), .rspAvail(rspAvail), .rspLocked(rspLocked),
    .rspWay(rspWay), .rspAddr(rspAddr), .errFlag(errFlag));

  function automatic logic [AW-1:0] la(input int tag, input int set);
    return AW'(tag) << 8 | AW'(set) << 6;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [AW-1:0] a, input logic [1:0] k,
                       input logic [2:0] p, input logic [3:0] x, input logic t);
    reqValid = 1'b1; reqCmd = c; reqAddr = a; reqKind = k; reqPerm = p;
    reqCtx = x; reqTouch = t;
  endtask

  task automatic issue(input logic [3:0] c, input logic [AW-1:0] a,
                       input logic [1:0] k = 0, input logic [2:0] p = 0,
                       input logic [3:0] x = 0, input logic t = 1'b1);
    @(negedge clk);
    drive(c, a, k, p, x, t);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R12", "err after reset", errFlag, 0);
    issue(PRS, la(1, 0));
    chk("R1", "rspValid", rspValid, 1);
    chk("R12", "empty miss", rspHit, 0);
    @(negedge clk);
    chk("R1", "rspValid idle", rspValid, 0);
    issue(AVL, la(1, 0));
    chk("R12", "avail", rspAvail, 1);
  endtask

  task automatic t_alloc();
    issue(ALC, la(1, 0));
    chk("R6", "first way", rspWay, 0);
    issue(ALC, la(2, 0));
    chk("R6", "second way", rspWay, 1);
    issue(PRS, la(2, 0));
    chk("R4", "present hit", rspHit, 1);
    chk("R4", "present way", rspWay, 1);
    issue(ACC, la(1, 0), ST);
    chk("R3", "invalid hit", rspHit, 1);
    chk("R3", "invalid no grant", rspGranted, 0);
    issue(LTS, la(1, 0), 0, 0, 4'hF);
    chk("R6", "lock no owner", rspLocked, 1);
    issue(LTS, la(1, 0), 0, 0, 4'h3);
    chk("R6", "lock not ctx3", rspLocked, 0);
  endtask

  task automatic t_perm();
    issue(SPM, la(1, 0), 0, RW);
    issue(ACC, la(1, 0), AT);
    chk("R10", "rw atomic grant", rspGranted, 1);
    issue(SPM, la(2, 0), 0, RO);
    issue(ACC, la(2, 0), LD);
    chk("R3", "ro load grant", rspGranted, 1);
    issue(ACC, la(2, 0), IF);
    chk("R3", "ro fetch grant", rspGranted, 1);
    issue(ACC, la(2, 0), ST);
    chk("R3", "ro store hit", rspHit, 1);
    chk("R3", "ro store no grant", rspGranted, 0);
    issue(SPM, la(2, 0), 0, BSY);
    issue(ACC, la(2, 0), LD);
    chk("R3", "busy no grant", rspGranted, 0);
    issue(SPM, la(2, 0), 0, NP);
    issue(ACC, la(2, 0), LD);
    chk("R3", "notpresent miss", rspHit, 0);
    issue(ALC, la(3, 0));
    chk("R6", "reuse lowest way", rspWay, 1);
  endtask

  task automatic t_lru();
    for (int i = 0; i < 4; i++) issue(ALC, la(i + 1, 1));
    issue(AVL, la(9, 1));
    chk("R5", "full set unavailable", rspAvail, 0);
    issue(AVL, la(3, 1));
    chk("R5", "match available", rspAvail, 1);
    issue(AVL, la(9, 0));
    chk("R2", "other set available", rspAvail, 1);
    issue(PRS, la(1, 1));
    chk("R2", "same tag other set way", rspWay, 0);
    issue(PRB, la(9, 1));
    chk("R8", "victim way", rspWay, 0);
    chk("R8", "victim addr", rspAddr, la(1, 1));
    issue(ACC, la(1, 1), LD);
    issue(PRB, la(9, 1));
    chk("R8", "victim after touch", rspAddr, la(2, 1));
    issue(ACC, la(2, 1), IF);
    issue(PRB, la(9, 1));
    chk("R8", "victim after second touch", rspWay, 2);
  endtask

  task automatic t_back2back();
    for (int i = 0; i < 4; i++) issue(ALC, la(i + 1, 2), 0, 0, 0, 1'b0);
    issue(PRB, la(9, 2));
    chk("R6", "untouched alloc victim", rspWay, 3);
    @(negedge clk);
    drive(ACC, la(4, 2), LD, 0, 0, 1'b0);
    @(negedge clk);
    chk("R3", "b2b access hit", rspHit, 1);
    drive(PRB, la(9, 2), 0, 0, 0, 1'b0);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8", "b2b probe sees touch", rspAddr, la(3, 2));
    @(negedge clk);
    drive(ALC, la(2, 3), 0, 0, 0, 1'b1);
    @(negedge clk);
    chk("R6", "b2b alloc way", rspWay, 0);
    drive(PRS, la(2, 3), 0, 0, 0, 1'b0);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R4", "b2b present", rspHit, 1);
  endtask

  task automatic t_lock();
    issue(ALC, la(1, 3));
    issue(LCK, la(1, 3), 0, 0, 4'd5);
    issue(LTS, la(1, 3), 0, 0, 4'd5);
    chk("R9", "locked by 5", rspLocked, 1);
    issue(LTS, la(1, 3), 0, 0, 4'd6);
    chk("R9", "not locked by 6", rspLocked, 0);
    issue(ULK, la(1, 3));
    issue(LTS, la(1, 3), 0, 0, 4'd5);
    chk("R9", "unlocked", rspLocked, 0);
    issue(LCK, la(1, 3), 0, 0, 4'd5);
    issue(DAL, la(1, 3));
    issue(PRS, la(1, 3));
    chk("R7", "dealloc miss", rspHit, 0);
    issue(ALC, la(1, 3));
    chk("R7", "freed way reused", rspWay, 1);
    issue(LTS, la(1, 3), 0, 0, 4'd5);
    chk("R6", "realloc clears lock", rspLocked, 0);
    chk("R11", "no error so far", errFlag, 0);
  endtask

  task automatic t_errors();
    issue(ALC, la(9, 1));
    chk("R6", "alloc full errs", errFlag, 1);
    issue(PRS, la(9, 1));
    chk("R11", "failed alloc absent", rspHit, 0);
    issue(PRB, la(9, 1));
    chk("R11", "victim unchanged", rspWay, 2);
    issue(DAL, la(1, 2) | 32'h4);
    issue(PRS, la(1, 2));
    chk("R11", "misaligned dealloc ignored", rspHit, 1);
    issue(ALC, la(1, 2));
    issue(PRS, la(1, 2));
    chk("R11", "dup alloc keeps way", rspWay, 0);
    chk("R11", "sticky", errFlag, 1);
    do_reset();
    chk("R12", "reset clears err", errFlag, 0);
    issue(PRS, la(1, 2));
    chk("R12", "reset empties", rspHit, 0);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_alloc();
    t_perm();
    t_lru();
    t_back2back();
    t_lock();
    t_errors();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule